// File: doc/BRIEF.md
# Key-Guarded GPIO Bank Register File

This block is the register file of a general-purpose pin controller. Pins are grouped in banks of 32, and up to eight banks can be instantiated. Each pin has its own configuration word. Bit 0 of that word picks the direction, and the word also holds fields for edge selection and input filtering, which are exported for neighbouring logic. Each bank has four registers. One reads back the driven output values. One reads back the synchronized pad levels. One sets output bits and one clears output bits; both are write-one-to-act.

A per-bank lock register protects pins from stray writes. While a pin's lock bit is 1, writes to its configuration word, its set bit and its clear bit have no effect. Reads are never blocked. The lock register itself only accepts a write that comes directly after a write of a fixed key value to a shared key register. That sequencing is held by a two-state key machine:

- KEY_IDLE: the reset state.
- The ARM transition leads from KEY_IDLE to KEY_ARMED on a key write with the correct code.
- KEY_ARMED: the state that lets the next lock write through.
- The DISARM transition leads from KEY_ARMED back to KEY_IDLE on any other bus write. This includes the lock write that consumes the key.
- A correct key write while in KEY_ARMED holds the state.

Top module: `gpio_keyed_bank_regs`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0), pin_out is all 0, every lock register reads 0xFFFFFFFF, and every configuration word reads 0x001.
- R2: A write of 0x00A5A501 to the key register (0x520) arms the key. If the very next bus write targets a lock register (0x500 + 4*bank), the lock register takes the written data. A 1 bit locks a pin and a 0 bit unlocks it. A second correct key write keeps the key armed.
- R3: A lock write that does not directly follow a correct key write is ignored. Any other bus write disarms the key, including a key write with a wrong value, a write to any other address, and the lock write itself.
- R4: Writing the set register (0x040 + 4*bank) raises the stored output of every unlocked pin whose data bit is 1. Zero bits leave their pins unchanged.
- R5: Writing the clear register (0x060 + 4*bank) lowers the stored output of every unlocked pin whose data bit is 1. Zero bits leave their pins unchanged.
- R6: While a pin's lock bit is 1, writes to its configuration word, set bit or clear bit leave that pin's state unchanged.
- R7: Configuration bit 0 set to 1 makes the pin an input and 0 makes it an output, so pin_oe equals the inverse of bit 0. Set and clear writes still update the stored value of an input pin, and that value appears on pin_out and in output status, but its pin_oe stays 0.
- R8: The output status register (0x000 + 4*bank) reads the stored output values. The input status register (0x020 + 4*bank) reads pad_in after a two-flop synchronizer, so a pad change becomes visible after the second rising clock edge.
- R9: The configuration word of pin n sits at 0x100 + 4*n. Only bits 8:0 are stored. They read back zero-extended, and all pins' words are exported on pin_cfg, with pin n at bits 9n+8:9n.
- R10: Addresses that map to no register, or to a bank beyond NUM_BANKS, read 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_BANKS*32 | Asynchronous pad levels |
| pin_out | output | NUM_BANKS*32 | Stored output value per pin |
| pin_oe | output | NUM_BANKS*32 | Output enable per pin, 1 = drive |
| pin_cfg | output | NUM_BANKS*32*9 | Configuration word per pin |

## Verification
Some properties are checked on every cycle. One is that the key machine arms on a correct key write and falls back on any other write. Another is that a lock register never changes on a write made without the key. A third is that a locked pin's configuration word and output bit stay put across any write. Other behaviours only the bench scenarios can show. These cover the exact read-back of each register kind, the per-bit masking of set and clear against the lock bits, the split between stored value and output enable on input pins, the two-edge latency of the input synchronizer, and the decoding of unmapped or out-of-range addresses. The bench sweeps every pin of a two-bank build against an arithmetic model.

// File: rtl/gkb_pkg.sv
package gkb_pkg;
    localparam int BUS_AW        = 12;
    localparam int DATA_W        = 32;
    localparam int PINS_PER_BANK = 32;
    localparam int MAX_BANKS     = 8;
    localparam int CFG_W         = 9;
    localparam int BANK_IW       = 3;
    localparam int BIT_IW        = 5;

    localparam logic [DATA_W-1:0] KEY_CODE = 32'h00A5_A501;

    // Byte offsets; software depends on these positions.
    localparam logic [BUS_AW-1:0] OFS_OUT  = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_IN   = 12'h020;
    localparam logic [BUS_AW-1:0] OFS_SET  = 12'h040;
    localparam logic [BUS_AW-1:0] OFS_CLR  = 12'h060;
    localparam logic [BUS_AW-1:0] OFS_CTRL = 12'h100;
    localparam logic [BUS_AW-1:0] OFS_LOCK = 12'h500;
    localparam logic [BUS_AW-1:0] OFS_KEY  = 12'h520;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_OUT_STAT,
        RK_IN_STAT,
        RK_SET,
        RK_CLR,
        RK_CTRL,
        RK_LOCK,
        RK_KEY
    } reg_kind_t;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_state_t;
endpackage

// File: rtl/gkb_decode.sv
module gkb_decode
    import gkb_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic [BUS_AW-1:0]  addr,
    output reg_kind_t          kind,
    output logic [BANK_IW-1:0] bank,
    output logic [BIT_IW-1:0]  bit_idx
);
    localparam int NPINS = NUM_BANKS * PINS_PER_BANK;
    localparam logic [BUS_AW-1:0] CTRL_END = OFS_CTRL + BUS_AW'(NPINS * 4);

    logic [7:0] pin_w;
    logic       bank_ok;

    always_comb begin
        kind    = RK_NONE;
        bank    = '0;
        bit_idx = '0;
        pin_w   = 8'(addr[10:2] - 9'd64);
        bank_ok = (32'(addr[4:2]) < NUM_BANKS);
        if (addr[1:0] == 2'b00) begin
            if (addr >= OFS_CTRL && addr < CTRL_END) begin
                kind    = RK_CTRL;
                bank    = pin_w[7:5];
                bit_idx = pin_w[4:0];
            end else if (bank_ok) begin
                case (addr[BUS_AW-1:5])
                    OFS_OUT[BUS_AW-1:5]:  kind = RK_OUT_STAT;
                    OFS_IN[BUS_AW-1:5]:   kind = RK_IN_STAT;
                    OFS_SET[BUS_AW-1:5]:  kind = RK_SET;
                    OFS_CLR[BUS_AW-1:5]:  kind = RK_CLR;
                    OFS_LOCK[BUS_AW-1:5]: kind = RK_LOCK;
                    default:              kind = RK_NONE;
                endcase
                if (kind != RK_NONE) bank = addr[4:2];
            end
            if (addr == OFS_KEY) begin
                kind = RK_KEY;
                bank = '0;
            end
        end
    end
endmodule

// File: rtl/gkb_keyfsm.sv
module gkb_keyfsm
    import gkb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_kind_t         kind,
    input  logic [DATA_W-1:0] wr_data,
    output logic              armed
);
    key_state_t state_q, state_d;
    logic       key_hit;

    assign key_hit = wr_en && (kind == RK_KEY) && (wr_data == KEY_CODE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE:  if (key_hit)           state_d = KEY_ARMED; // ARM
            KEY_ARMED: if (wr_en && !key_hit) state_d = KEY_IDLE;  // DISARM
            default:                          state_d = KEY_IDLE;
        endcase
    end

    always_comb begin
        armed = (state_q == KEY_ARMED);
    end

    AST_ARM_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == RK_KEY && wr_data == KEY_CODE) |=> armed); // R2

    AST_DISARM_ON_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(kind == RK_KEY && wr_data == KEY_CODE)) |=> !armed); // R3
endmodule

// File: rtl/gkb_sync.sv
module gkb_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gkb_bank.sv
module gkb_bank
    import gkb_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  reg_kind_t                               kind,
    input  logic [BANK_IW-1:0]                      bank,
    input  logic [BIT_IW-1:0]                       bit_idx,
    input  logic [DATA_W-1:0]                       wr_data,
    input  logic                                    armed,
    output logic [PINS_PER_BANK-1:0]                out_q,
    output logic [PINS_PER_BANK-1:0]                lock_q,
    output logic [PINS_PER_BANK-1:0][CFG_W-1:0]     ctrl_q
);
    logic                     hit;
    logic [PINS_PER_BANK-1:0] set_mask;
    logic [PINS_PER_BANK-1:0] clr_mask;

    assign hit = wr_en && (bank == BANK_IW'(BANK_ID));

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (hit && kind == RK_SET) set_mask = wr_data & ~lock_q;
        if (hit && kind == RK_CLR) clr_mask = wr_data & ~lock_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                   out_q <= '0;
        else if (hit && (kind == RK_SET || kind == RK_CLR))
            out_q <= (out_q | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                  lock_q <= '1;
        else if (hit && kind == RK_LOCK && armed)    lock_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < PINS_PER_BANK; p++) begin
            if (!rst_n)
                ctrl_q[p] <= CFG_W'(1);
            else if (hit && kind == RK_CTRL && bit_idx == BIT_IW'(p) && !lock_q[p])
                ctrl_q[p] <= wr_data[CFG_W-1:0];
        end
    end

    AST_LOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == RK_LOCK && !armed) |=> $stable(lock_q)); // R3

    AST_LOCKED_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((out_q ^ $past(out_q)) & $past(lock_q)) == '0)); // R6

    for (genvar g = 0; g < PINS_PER_BANK; g++) begin : g_ctrl_chk
        AST_LOCKED_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q[g] |=> $stable(ctrl_q[g])); // R6
    end
endmodule

// File: rtl/gpio_keyed_bank_regs.sv
module gpio_keyed_bank_regs
    import gkb_pkg::*;
#(
    parameter  int NUM_BANKS = 2,
    localparam int NPINS     = NUM_BANKS * PINS_PER_BANK
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BUS_AW-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NPINS-1:0]        pad_in,
    output logic [NPINS-1:0]        pin_out,
    output logic [NPINS-1:0]        pin_oe,
    output logic [NPINS*CFG_W-1:0]  pin_cfg
);
    reg_kind_t          kind;
    logic [BANK_IW-1:0] bank;
    logic [BIT_IW-1:0]  bit_idx;
    logic               armed;
    logic [NPINS-1:0]   pad_sync;

    logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0]            out_all;
    logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0]            lock_all;
    logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0][CFG_W-1:0] ctrl_all;

    gkb_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .addr    (bus_addr),
        .kind    (kind),
        .bank    (bank),
        .bit_idx (bit_idx)
    );

    gkb_keyfsm u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .kind    (kind),
        .wr_data (bus_wdata),
        .armed   (armed)
    );

    gkb_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gkb_bank #(.BANK_ID(b)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr),
            .kind    (kind),
            .bank    (bank),
            .bit_idx (bit_idx),
            .wr_data (bus_wdata),
            .armed   (armed),
            .out_q   (out_all[b]),
            .lock_q  (lock_all[b]),
            .ctrl_q  (ctrl_all[b])
        );
    end

    assign pin_out = out_all;
    assign pin_cfg = ctrl_all;

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++)
            for (int p = 0; p < PINS_PER_BANK; p++)
                pin_oe[b*PINS_PER_BANK + p] = ~ctrl_all[b][p][0];
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == BANK_IW'(b)) begin
                unique case (kind)
                    RK_OUT_STAT: bus_rdata = out_all[b];
                    RK_IN_STAT:  bus_rdata = pad_sync[b*PINS_PER_BANK +: PINS_PER_BANK];
                    RK_LOCK:     bus_rdata = lock_all[b];
                    RK_CTRL:     bus_rdata = DATA_W'(ctrl_all[b][bit_idx]);
                    default:     bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/gpio_keyed_bank_regs_tb.sv
`timescale 1ns/1ps
module gpio_keyed_bank_regs_tb;
    localparam int NB = 2;
    localparam int NP = NB * 32;
    localparam int CW = 9;
    localparam logic [31:0] KEY = 32'h00A5_A501;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [11:0]     bus_addr;
    logic            bus_wr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pad_in;
    logic [NP-1:0]   pin_out;
    logic [NP-1:0]   pin_oe;
    logic [NP*CW-1:0] pin_cfg;

    always #5 clk = ~clk;

    gpio_keyed_bank_regs #(.NUM_BANKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_cfg(pin_cfg)
    );

    // Reference model
    logic [31:0]   m_lock [NB];
    logic [31:0]   m_out  [NB];
    logic [CW-1:0] m_ctrl [NP];
    logic          m_armed;
    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rv;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_oe();
        logic [63:0] r;
        for (int p = 0; p < NP; p++) r[p] = ~m_ctrl[p][0];
        return r;
    endfunction

    function automatic logic [63:0] exp_out();
        return {m_out[1], m_out[0]};
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int b;
        b = int'(a[4:2]);
        if (a == 12'h520) begin
            m_armed = (d == KEY);
        end else begin
            if (a >= 12'h100 && a < 12'h100 + NP*4 && a[1:0] == 0) begin
                int p;
                p = (int'(a) - 'h100) / 4;
                if (!m_lock[p/32][p%32]) m_ctrl[p] = d[CW-1:0];
            end else if (b < NB && a[1:0] == 0) begin
                if (a[11:5] == 7'h02) m_out[b] = m_out[b] | (d & ~m_lock[b]);
                if (a[11:5] == 7'h03) m_out[b] = m_out[b] & ~(d & ~m_lock[b]);
                if (a[11:5] == 7'h28 && m_armed) m_lock[b] = d;
            end
            m_armed = 1'b0;
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        model_write(a, d);
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " pin_out"}, pin_out, exp_out());
        chk({tag, " pin_oe"}, pin_oe, exp_oe());
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
        m_armed = 1'b0;
        for (int b = 0; b < NB; b++) begin m_lock[b] = '1; m_out[b] = '0; end
        for (int p = 0; p < NP; p++) m_ctrl[p] = CW'(1);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 oe", pin_oe, 64'h0);
        chk("R1 out", pin_out, 64'h0);
        rd(12'h500, rv); chk("R1 lock0", rv, 32'hFFFF_FFFF);
        rd(12'h504, rv); chk("R1 lock1", rv, 32'hFFFF_FFFF);
        for (int p = 0; p < NP; p++) begin
            rd(12'(12'h100 + p*4), rv); chk("R1 cfg word", rv, 32'h1);
        end

        // R10 unmapped and out-of-range reads
        rd(12'h008, rv); chk("R10 bank2 out", rv, 0);
        rd(12'h080, rv); chk("R10 0x080", rv, 0);
        rd(12'h508, rv); chk("R10 bank2 lock", rv, 0);
        rd(12'h200, rv); chk("R10 ctrl past end", rv, 0);

        // R3 lock writes without a directly preceding key
        wr(12'h500, 32'h0); rd(12'h500, rv); chk("R3 no key", rv, m_lock[0]);
        wr(12'h520, KEY); wr(12'h040, 32'h0); wr(12'h500, 32'h0);
        rd(12'h500, rv); chk("R3 key then other write", rv, m_lock[0]);
        wr(12'h520, KEY ^ 32'h1); wr(12'h500, 32'h0);
        rd(12'h500, rv); chk("R3 wrong key", rv, m_lock[0]);

        // R6 all pins locked
        wr(12'h114, 32'h0); rd(12'h114, rv); chk("R6 locked cfg", rv, 32'h1);
        wr(12'h040, 32'hFFFF_FFFF); rd(12'h000, rv); chk("R6 locked set", rv, 32'h0);

        // R2 keyed lock writes
        wr(12'h520, KEY); wr(12'h500, 32'h0000_FFFF);
        rd(12'h500, rv); chk("R2 lock0", rv, 32'h0000_FFFF);
        wr(12'h520, KEY); wr(12'h520, KEY); wr(12'h504, 32'h0);
        rd(12'h504, rv); chk("R2 double key", rv, 32'h0);
        wr(12'h504, 32'hFFFF_FFFF);
        rd(12'h504, rv); chk("R3 key consumed", rv, 32'h0);

        // R9/R7 configuration sweep
        for (int p = 0; p < NP; p++)
            wr(12'(12'h100 + p*4), 32'hFFFF_FE00 | ((p*37) & 32'h1FF));
        for (int p = 0; p < NP; p++) begin
            rd(12'(12'h100 + p*4), rv); chk("R9 cfg read", rv, 32'(m_ctrl[p]));
            chk("R9 pin_cfg", 64'(pin_cfg[p*CW +: CW]), 64'(m_ctrl[p]));
        end
        chk("R7 oe after sweep", pin_oe, exp_oe());

        // R4 set, R5 clear
        wr(12'h040, 32'hA5A5_5A5A); wr(12'h044, 32'h3C3C_C3C3);
        rd(12'h000, rv); chk("R4 out0", rv, m_out[0]);
        rd(12'h004, rv); chk("R4 out1", rv, m_out[1]);
        chk_state("R4");
        wr(12'h060, 32'h0F0F_0F0F); wr(12'h064, 32'hFFFF_0000);
        rd(12'h000, rv); chk("R5 out0", rv, m_out[0]);
        rd(12'h004, rv); chk("R5 out1", rv, m_out[1]);
        chk_state("R5");

        // R7 input pin 33 keeps its value but is not driven
        chk("R7 pin33 oe", 64'(pin_oe[33]), 64'h0);
        chk("R7 pin33 out", 64'(pin_out[33]), 64'h1);

        // Unlock bank 0, then relock alternate pins
        wr(12'h520, KEY); wr(12'h500, 32'h0);
        wr(12'h040, 32'hFFFF_FFFF);
        rd(12'h000, rv); chk("R4 unlocked set", rv, 32'hFFFF_FFFF);
        wr(12'h114, 32'h0); rd(12'h114, rv); chk("R9 unlocked cfg", rv, 32'h0);
        wr(12'h520, KEY); wr(12'h500, 32'hAAAA_AAAA);
        wr(12'h060, 32'hFFFF_FFFF);
        rd(12'h000, rv); chk("R6 partial lock clear", rv, 32'hAAAA_AAAA);
        chk_state("R6");

        // R8 two-flop input synchronizer
        for (int k = 0; k < 4; k++) begin
            logic [63:0] old_v, new_v;
            old_v = pad_in;
            new_v = {32'(k) * 32'h1357_9BDF, 32'(k+1) * 32'h2468_ACE1};
            @(negedge clk);
            pad_in = new_v; bus_addr = 12'h020; bus_wr = 1'b0;
            #1 chk("R8 before edges", bus_rdata, old_v[31:0]);
            @(negedge clk);
            #1 chk("R8 after one edge", bus_rdata, old_v[31:0]);
            @(negedge clk);
            #1 chk("R8 after two edges", bus_rdata, new_v[31:0]);
            rd(12'h024, rv); chk("R8 bank1", rv, new_v[63:32]);
        end

        // R10 write to unmapped address disarms and changes nothing
        wr(12'h520, KEY); wr(12'h600, 32'hFFFF_FFFF); wr(12'h500, 32'h0);
        rd(12'h500, rv); chk("R10 unmapped write", rv, 32'hAAAA_AAAA);
        wr(12'h048, 32'hFFFF_FFFF);
        chk_state("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule